// File: doc/BRIEF.md
# Sound Chip Bus Bridge

This block connects a processor's two-register window to a sound-generator chip that is addressed in two phases: an address phase selects a chip register and a data phase moves the value. The processor first writes a command code into the command register. The command code then decides what each later access to the data register does. It can latch a chip register address, write data to the chip, read data back, read the chip status, or read the joystick port.

Two variants are built from the same source, chosen by the `FM_STYLE` parameter. The plain tone-chip variant has a 2-bit command. The FM-chip variant has a 4-bit command whose upper two bits select the status and joystick reads. The chip-side writes are one-cycle strobes that are registered after the processor write. The chip-side reads are combinational, so read data returns in the same cycle as the processor read. The `chip_fitted` strap says whether the chip is installed. When it is low, the bridge reads as all ones and ignores every write. The bridge holds no sound logic.

Top module: `sound_bus_bridge`

## Requirements
- R1: After reset the command code is 0, the address latch `chip_addr` is 0, and neither `chip_wr_en` nor `chip_rd_en` is asserted.
- R2: A command-register read returns the stored code in the low bits with every bit above it set to one (FM variant: 4-bit code, bits 7..4 one; tone variant: 2-bit code, bits 7..2 one). Written bits above the code width are dropped.
- R3: With basic code 0, a data-register write produces no chip strobe and a data-register read returns 0xFF without `chip_rd_en`.
- R4: With basic code 1, a data-register read asserts `chip_rd_en` in the same cycle with `chip_rd_src` = 0 (data) and returns `chip_rdata`. A data-register write under code 1 produces no strobe.
- R5: With basic code 2, every data-register write raises `chip_wr_en` for exactly the following cycle, with `chip_wr_is_addr` = 0 and `chip_wr_data` equal to the written byte. A data-register read under code 2 is a conflict: it returns 0xFF and does not assert `chip_rd_en`.
- R6: With basic code 3, a data-register write stores bits 3..0 into `chip_addr` and raises a one-cycle strobe on the following cycle with `chip_wr_is_addr` = 1 and `chip_wr_data` = {0000, bits 3..0}. A data-register read under code 3 returns 0xFF.
- R7: In the FM variant, command bit 3 selects a joystick read (`chip_rd_src` = 2). This selection wins over bit 2 and over the basic code.
- R8: In the FM variant, command bit 2 with bit 3 clear selects a status read (`chip_rd_src` = 1). This selection wins over the basic code.
- R9: In the FM variant, a data-register write while bit 3 or bit 2 is set produces no strobe and leaves `chip_addr` unchanged.
- R10: While `chip_fitted` is low, every read returns 0xFF, `chip_rd_en` stays low, and writes to either register have no effect. A command written during that time is absent once the chip is fitted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_fitted | input | 1 | High when the sound chip is installed |
| cpu_cs | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg_sel | input | 1 | 0 = command register, 1 = data register |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (0xFF when not reading) |
| chip_wr_en | output | 1 | One-cycle chip write strobe |
| chip_wr_is_addr | output | 1 | Strobe is an address phase (1) or data phase (0) |
| chip_wr_data | output | 8 | Value driven with the write strobe |
| chip_addr | output | 4 | Latched chip register address |
| chip_rd_en | output | 1 | Chip read in progress (combinational) |
| chip_rd_src | output | 2 | Read source: 0 data, 1 status, 2 joystick |
| chip_rdata | input | 8 | Data returned by the chip |

## Verification
The bench drives both variants side by side from the same stimulus, so every command byte is decoded two ways in parallel. It aims at the following corner cases:
- Priority of the FM upper bits. Testing bit 3 after bit 2 would report a status read when joystick was selected, and testing the basic code first would strobe the chip under a status command.
- Back-to-back data writes. A stretched or edge-detected strobe would merge two writes into one.
- The write-conflict read under code 2. A design that forwarded the chip data there would return chip bytes instead of 0xFF.
- A command written while the chip is absent. A design that stored it would show the wrong code when the chip is fitted again.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  typedef enum logic [1:0] {
    RDK_NONE   = 2'd0,
    RDK_DATA   = 2'd1,
    RDK_STATUS = 2'd2,
    RDK_JOY    = 2'd3
  } rd_kind_e;

  typedef enum logic [1:0] {
    WRK_NONE = 2'd0,
    WRK_DATA = 2'd1,
    WRK_ADDR = 2'd2
  } wr_kind_e;

  localparam logic [1:0] SRC_DATA   = 2'd0;
  localparam logic [1:0] SRC_STATUS = 2'd1;
  localparam logic [1:0] SRC_JOY    = 2'd2;

endpackage

// File: rtl/sbb_cmd_reg.sv
module sbb_cmd_reg #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_code,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] readback
);

  localparam int PAD_W = DATA_W - CMD_W;

  always_ff @(posedge clk) begin
    if (!rst_n)     cmd_q <= '0;
    else if (wr_en) cmd_q <= wr_code;
  end

  assign readback = {{PAD_W{1'b1}}, cmd_q};

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cmd_q)); // R2

endmodule

// File: rtl/sbb_decode.sv
module sbb_decode import sbb_pkg::*; #(
  parameter int CMD_W = 4
) (
  input  logic [CMD_W-1:0] cmd_q,
  output rd_kind_e         rd_kind,
  output wr_kind_e         wr_kind
);

  logic joy_sel;
  logic stat_sel;

  generate
    if (CMD_W >= 4) begin : g_fm
      assign joy_sel  = cmd_q[3];
      assign stat_sel = cmd_q[2];
    end else begin : g_tone
      assign joy_sel  = 1'b0;
      assign stat_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_kind = RDK_NONE;
    wr_kind = WRK_NONE;
    if (joy_sel) begin
      rd_kind = RDK_JOY;
    end else if (stat_sel) begin
      rd_kind = RDK_STATUS;
    end else begin
      unique case (cmd_q[1:0])
        2'd1:    rd_kind = RDK_DATA;
        2'd2:    wr_kind = WRK_DATA;
        2'd3:    wr_kind = WRK_ADDR;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sbb_chip_port.sv
module sbb_chip_port import sbb_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  wr_kind_e          wr_kind,
  input  rd_kind_e          rd_kind,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] chip_rdata,
  output logic              chip_wr_en,
  output logic              chip_wr_is_addr,
  output logic [DATA_W-1:0] chip_wr_data,
  output logic [ADDR_W-1:0] chip_addr,
  output logic              chip_rd_en,
  output logic [1:0]        chip_rd_src,
  output logic [DATA_W-1:0] rd_value
);

  localparam int ZPAD_W = DATA_W - ADDR_W;

  logic do_data_wr;
  logic do_addr_wr;

  assign do_data_wr = acc_wr && (wr_kind == WRK_DATA);
  assign do_addr_wr = acc_wr && (wr_kind == WRK_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_wr_en      <= 1'b0;
      chip_wr_is_addr <= 1'b0;
      chip_wr_data    <= '0;
      chip_addr       <= '0;
    end else begin
      chip_wr_en <= do_data_wr || do_addr_wr;
      if (do_addr_wr) begin
        chip_addr       <= cpu_wdata[ADDR_W-1:0];
        chip_wr_is_addr <= 1'b1;
        chip_wr_data    <= {{ZPAD_W{1'b0}}, cpu_wdata[ADDR_W-1:0]};
      end else if (do_data_wr) begin
        chip_wr_is_addr <= 1'b0;
        chip_wr_data    <= cpu_wdata;
      end
    end
  end

  always_comb begin
    chip_rd_en  = acc_rd && (rd_kind != RDK_NONE);
    chip_rd_src = SRC_DATA;
    unique case (rd_kind)
      RDK_STATUS: chip_rd_src = SRC_STATUS;
      RDK_JOY:    chip_rd_src = SRC_JOY;
      default:    chip_rd_src = SRC_DATA;
    endcase
    rd_value = chip_rd_en ? chip_rdata : '1;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(do_addr_wr) |-> $stable(chip_addr)); // R6

  AST_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    chip_wr_en |-> $past(acc_wr && (wr_kind != WRK_NONE))); // R9

endmodule

// File: rtl/sound_bus_bridge.sv
module sound_bus_bridge import sbb_pkg::*; #(
  parameter bit FM_STYLE = 1'b1,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_fitted,
  input  logic              cpu_cs,
  input  logic              cpu_we,
  input  logic              cpu_reg_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              chip_wr_en,
  output logic              chip_wr_is_addr,
  output logic [DATA_W-1:0] chip_wr_data,
  output logic [ADDR_W-1:0] chip_addr,
  output logic              chip_rd_en,
  output logic [1:0]        chip_rd_src,
  input  logic [DATA_W-1:0] chip_rdata
);

  localparam int CMD_W = FM_STYLE ? 4 : 2;

  logic              cmd_wr;
  logic              cmd_rd;
  logic              dat_wr;
  logic              dat_rd;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] cmd_readback;
  logic [DATA_W-1:0] port_rd_value;
  rd_kind_e          rd_kind;
  wr_kind_e          wr_kind;

  assign cmd_wr = chip_fitted && cpu_cs && !cpu_reg_sel &&  cpu_we;
  assign cmd_rd = chip_fitted && cpu_cs && !cpu_reg_sel && !cpu_we;
  assign dat_wr = chip_fitted && cpu_cs &&  cpu_reg_sel &&  cpu_we;
  assign dat_rd = chip_fitted && cpu_cs &&  cpu_reg_sel && !cpu_we;

  sbb_cmd_reg #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmd_wr),
    .wr_code  (cpu_wdata[CMD_W-1:0]),
    .cmd_q    (cmd_q),
    .readback (cmd_readback)
  );

  sbb_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_q   (cmd_q),
    .rd_kind (rd_kind),
    .wr_kind (wr_kind)
  );

  sbb_chip_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_wr          (dat_wr),
    .acc_rd          (dat_rd),
    .wr_kind         (wr_kind),
    .rd_kind         (rd_kind),
    .cpu_wdata       (cpu_wdata),
    .chip_rdata      (chip_rdata),
    .chip_wr_en      (chip_wr_en),
    .chip_wr_is_addr (chip_wr_is_addr),
    .chip_wr_data    (chip_wr_data),
    .chip_addr       (chip_addr),
    .chip_rd_en      (chip_rd_en),
    .chip_rd_src     (chip_rd_src),
    .rd_value        (port_rd_value)
  );

  always_comb begin
    if (cmd_rd)      cpu_rdata = cmd_readback;
    else if (dat_rd) cpu_rdata = port_rd_value;
    else             cpu_rdata = '1;
  end

  AST_STROBE_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    chip_wr_en |-> $past(cpu_cs && cpu_we && cpu_reg_sel && chip_fitted)); // R5

  AST_RD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rd_en |-> (cpu_cs && !cpu_we && cpu_reg_sel && chip_fitted)); // R4

  AST_ABSENT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_fitted && cpu_cs && !cpu_we) |-> (cpu_rdata == '1 && !chip_rd_en)); // R10

  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_readback[CMD_W-1:0] == '0) |-> !chip_rd_en); // R3

endmodule

// File: tb/sound_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module sound_bus_bridge_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fitted = 1'b1;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic       rsel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] crdata = 8'h5a;

  logic [7:0] o_rdata [2];
  logic       o_wr    [2];
  logic       o_wa    [2];
  logic [7:0] o_wd    [2];
  logic [3:0] o_addr  [2];
  logic       o_rd    [2];
  logic [1:0] o_src   [2];

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sound_bus_bridge #(.FM_STYLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_fitted(fitted), .cpu_cs(cs), .cpu_we(we),
    .cpu_reg_sel(rsel), .cpu_wdata(wdata), .cpu_rdata(o_rdata[0]),
    .chip_wr_en(o_wr[0]), .chip_wr_is_addr(o_wa[0]), .chip_wr_data(o_wd[0]),
    .chip_addr(o_addr[0]), .chip_rd_en(o_rd[0]), .chip_rd_src(o_src[0]),
    .chip_rdata(crdata));

  sound_bus_bridge #(.FM_STYLE(1'b0)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .chip_fitted(fitted), .cpu_cs(cs), .cpu_we(we),
    .cpu_reg_sel(rsel), .cpu_wdata(wdata), .cpu_rdata(o_rdata[1]),
    .chip_wr_en(o_wr[1]), .chip_wr_is_addr(o_wa[1]), .chip_wr_data(o_wd[1]),
    .chip_addr(o_addr[1]), .chip_rd_en(o_rd[1]), .chip_rd_src(o_src[1]),
    .chip_rdata(crdata));

  // Behavioural reference: index 0 = FM variant, index 1 = tone variant
  logic [3:0] m_cmd  [2];
  logic [3:0] m_addr [2];
  logic       m_wp   [2];
  logic       m_wa   [2];
  logic [7:0] m_wd   [2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cmd[i] <= 4'h0; m_addr[i] <= 4'h0; m_wp[i] <= 1'b0;
        m_wa[i] <= 1'b0; m_wd[i] <= 8'h00;
      end else begin
        m_wp[i] <= 1'b0;
        if (cs && we && fitted) begin
          if (!rsel) begin
            m_cmd[i] <= (i == 0) ? wdata[3:0] : {2'b00, wdata[1:0]};
          end else if (!(i == 0 && m_cmd[i][3:2] != 2'b00)) begin
            if (m_cmd[i][1:0] == 2'd2) begin
              m_wp[i] <= 1'b1; m_wa[i] <= 1'b0; m_wd[i] <= wdata;
            end else if (m_cmd[i][1:0] == 2'd3) begin
              m_wp[i] <= 1'b1; m_wa[i] <= 1'b1; m_wd[i] <= {4'h0, wdata[3:0]};
              m_addr[i] <= wdata[3:0];
            end
          end
        end
      end
    end
  end

  task automatic chk8(input int i, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s act=%h exp=%h t=%0t", cur_req, i, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 2; i++) begin
        logic       e_rd;
        logic [1:0] e_src;
        logic [7:0] e_val;
        e_rd = 1'b0; e_src = 2'd0; e_val = 8'hff;
        if (fitted && cs && !we) begin
          if (!rsel) begin
            e_val = (i == 0) ? {4'hf, m_cmd[i]} : {6'h3f, m_cmd[i][1:0]};
          end else if (i == 0 && m_cmd[i][3]) begin
            e_rd = 1'b1; e_src = 2'd2; e_val = crdata;
          end else if (i == 0 && m_cmd[i][2]) begin
            e_rd = 1'b1; e_src = 2'd1; e_val = crdata;
          end else if (m_cmd[i][1:0] == 2'd1) begin
            e_rd = 1'b1; e_src = 2'd0; e_val = crdata;
          end
        end
        chk8(i, "cpu_rdata", o_rdata[i], e_val);
        chk8(i, "chip_rd_en", {7'd0, o_rd[i]}, {7'd0, e_rd});
        if (e_rd) chk8(i, "chip_rd_src", {6'd0, o_src[i]}, {6'd0, e_src});
        chk8(i, "chip_wr_en", {7'd0, o_wr[i]}, {7'd0, m_wp[i]});
        if (m_wp[i]) begin
          chk8(i, "chip_wr_is_addr", {7'd0, o_wa[i]}, {7'd0, m_wa[i]});
          chk8(i, "chip_wr_data", o_wd[i], m_wd[i]);
        end
        chk8(i, "chip_addr", {4'd0, o_addr[i]}, {4'd0, m_addr[i]});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      crdata = crdata * 8'd5 + 8'h3b;
    end
  end

  task automatic acc(input logic c, input logic w, input logic r, input logic [7:0] d);
    @(posedge clk); #1;
    cs = c; we = w; rsel = r; wdata = d;
  endtask
  task automatic idle();           acc(1'b0, 1'b0, 1'b0, 8'h00); endtask
  task automatic cmd_wr(input logic [7:0] d); acc(1'b1, 1'b1, 1'b0, d); endtask
  task automatic cmd_rd();         acc(1'b1, 1'b0, 1'b0, 8'h00); endtask
  task automatic dat_wr(input logic [7:0] d); acc(1'b1, 1'b1, 1'b1, d); endtask
  task automatic dat_rd();         acc(1'b1, 1'b0, 1'b1, 8'h00); endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; idle(); cmd_rd(); idle();
    cur_req = "R2"; cmd_wr(8'ha5); cmd_rd(); cmd_wr(8'hfe); cmd_rd(); idle();
    cur_req = "R3"; cmd_wr(8'h00); dat_wr(8'h77); dat_rd(); idle();
    cur_req = "R4"; cmd_wr(8'h01); dat_rd(); dat_rd(); dat_rd(); dat_wr(8'h11); idle();
    cur_req = "R5"; cmd_wr(8'h02); dat_wr(8'h9c); dat_wr(8'h3d); idle(); dat_rd(); idle();
    cur_req = "R6"; cmd_wr(8'h03); dat_wr(8'hb7); dat_rd(); dat_wr(8'h0f); dat_wr(8'h52); idle();
    cur_req = "R8"; cmd_wr(8'h04); dat_rd(); dat_rd(); cmd_wr(8'h05); dat_rd(); idle();
    cur_req = "R7"; cmd_wr(8'h0c); dat_rd(); cmd_wr(8'h09); dat_rd(); dat_rd(); idle();
    cur_req = "R9"; cmd_wr(8'h0b); dat_wr(8'h66); idle(); cmd_wr(8'h06); dat_wr(8'h29); idle();
    cmd_wr(8'h0e); dat_wr(8'h01); cmd_rd(); idle();
    cur_req = "R10"; cmd_wr(8'h06); idle();
    fitted = 1'b0;
    cmd_rd(); cmd_wr(8'h03); dat_wr(8'h44); dat_rd(); idle();
    fitted = 1'b1;
    cmd_rd(); dat_wr(8'h35); idle(); idle();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule